// File: doc/BRIEF.md
# LED Print Head Line Controller

This block feeds one raster line of bit-image dots into a serial LED print head and then exposes the line in four time-divided groups. A page-sync pulse arms the controller. After that, each line-sync pulse starts a line. The controller pulls 32-bit line words from a buffer through a valid/ready read port. It shifts the dots out on the head clock, either one bit per clock on lane 0 or four bits per clock on lanes 0 to 3. The lane mode is sampled when a line is accepted.

When the last dot has been shifted, the controller raises an active-high load pulse so the head latches the line. It then drives four active-low group strobes, one after another. While those strobes run, the next line can already be shifted in. The latch for that next line is held back until the last strobe of the current line has ended. If a buffer word is missing when it is needed, the controller shifts blank dots and sets a sticky error flag. A line-sync that arrives while a line is still being transferred is counted and ignored.

The dot count, word width, head clock divide, load width and strobe width are all parameters counted in system clocks.

Top module: `hdLineDriver`

## Requirements
- R1: After reset, all strobes are high, `headLoad`, `headClk` and `wordReady` are low, `underrunErr` is low and `overrunCount` is zero.
- R2: A line-sync seen before any page-sync starts no line, produces no head clock and does not change `overrunCount`.
- R3: In single-lane mode (`quadLane`=0), a line gives exactly DOTS rising edges of `headClk`. On the n-th rising edge (counting from 0), `headData[0]` carries bit n%32 of line word n/32, and `headData[3:1]` are low.
- R4: In four-lane mode (`quadLane`=1), a line gives DOTS/4 rising edges of `headClk`. On the n-th rising edge, lane k carries line bit 4n+k, where line bit i is bit i%32 of word i/32.
- R5: Exactly DOTS/32 words are taken per line. A word is taken in a cycle where `wordValid` and `wordReady` are both high, and `headClk` is low in any cycle where `wordReady` is high.
- R6: After the last head clock of a line, `headLoad` goes high once, for LOAD_W cycles. It never goes high while any strobe of the previous line is still low.
- R7: After the load pulse, `strobeN[0]` to `strobeN[3]` each go low for STRB_W cycles, in that order. At most one strobe is low at any time, and no strobe is low while `headLoad` is high.
- R8: A line-sync accepted while the previous line's strobes are running starts shifting at once. Head clocks then overlap the exposure.
- R9: If `wordValid` is low when a word is needed, that word's 32 dots are shifted as zeros and `underrunErr` is set. The flag stays set until reset.
- R10: A line-sync arriving after a line is accepted and before its load pulse has finished increments `overrunCount`, which saturates at its maximum. The line in progress is not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pageSync | input | 1 | One-cycle pulse that arms line processing |
| lineSync | input | 1 | One-cycle pulse that requests a new line |
| quadLane | input | 1 | Lane mode, sampled when a line is accepted: 1 = four lanes, 0 = one lane |
| wordData | input | WORD_W | Line word from the buffer |
| wordValid | input | 1 | The buffer offers a word |
| wordReady | output | 1 | The controller takes the offered word |
| headClk | output | 1 | Head shift clock; data is taken on its rising edge |
| headData | output | 4 | Serial dot lanes |
| headLoad | output | 1 | Active-high latch pulse |
| strobeN | output | GROUPS | Active-low group strobes |
| underrunErr | output | 1 | Sticky flag for a missing buffer word |
| overrunCount | output | OVR_W | Saturating count of line-syncs ignored as overruns |

## Verification
The main transfer path is run with a table of word patterns in both lane modes. Runs of equal bits, alternating bytes and mixed nibbles show apart a wrong lane order, a wrong bit order within a word, and a skipped or repeated word. Timed line-syncs check the corner cases:
- one pulse issued before arming;
- one pulse during a shift, to check that the overrun is counted and the line is unharmed;
- one pulse during exposure, to check that the next shift overlaps the strobes while its latch waits.

A withheld buffer covers blanking and the sticky error flag, and a later full line shows that the data path recovers while the flag stays set.

// File: rtl/hd_pkg.sv
package hd_pkg;
  // Strobes sent from the line control to the shift datapath
  typedef struct packed {
    logic lineStart;  // a line was accepted this cycle
    logic slotStart;  // first cycle of a head-clock slot
    logic quad;       // lane mode latched for this line
  } hdCtl_t;
endpackage

// File: rtl/hdShiftPath.sv
module hdShiftPath
  import hd_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  hdCtl_t            ctl,
  input  logic [WORD_W-1:0] wordData,
  input  logic              wordValid,
  output logic              wordReady,
  output logic [3:0]        headData,
  output logic              underrunErr
);
  localparam int PTR_W = $clog2(WORD_W);

  logic [WORD_W-1:0] wordReg;
  logic [PTR_W-1:0]  bitPtr;
  logic [WORD_W-1:0] curWord;
  logic              wordEdge;

  assign wordEdge  = (bitPtr == '0);
  assign wordReady = ctl.slotStart && wordEdge;
  assign curWord   = wordEdge ? (wordValid ? wordData : '0) : wordReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordReg     <= '0;
      bitPtr      <= '0;
      headData    <= '0;
      underrunErr <= 1'b0;
    end else if (ctl.lineStart) begin
      bitPtr   <= '0;
      headData <= '0;
    end else if (ctl.slotStart) begin
      if (ctl.quad) begin
        headData <= curWord[3:0];
        wordReg  <= curWord >> 4;
        bitPtr   <= bitPtr + PTR_W'(4);
      end else begin
        headData <= {3'b000, curWord[0]};
        wordReg  <= curWord >> 1;
        bitPtr   <= bitPtr + PTR_W'(1);
      end
      if (wordEdge && !wordValid) underrunErr <= 1'b1;
    end
  end

  // R9
  sticky_underrun_chk: assert property (@(posedge clk) disable iff (!rstN)
    underrunErr |=> underrunErr);
endmodule

// File: rtl/hdStrobeSeq.sv
module hdStrobeSeq #(
  parameter int GROUPS = 4,
  parameter int STRB_W = 1024
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic [GROUPS-1:0] strobeN,
  output logic              busy
);
  localparam int G_W = (GROUPS > 1) ? $clog2(GROUPS) : 1;
  localparam int C_W = (STRB_W > 1) ? $clog2(STRB_W) : 1;

  logic           active;
  logic [G_W-1:0] grp;
  logic [C_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      grp    <= '0;
      cnt    <= '0;
    end else if (!active) begin
      if (start) begin
        active <= 1'b1;
        grp    <= '0;
        cnt    <= '0;
      end
    end else if (cnt == C_W'(STRB_W-1)) begin
      cnt <= '0;
      if (grp == G_W'(GROUPS-1)) active <= 1'b0;
      else grp <= grp + 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  for (genvar g = 0; g < GROUPS; g++) begin : g_strb
    assign strobeN[g] = !(active && grp == G_W'(g));
  end

  assign busy = active;

  // R7
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~strobeN));
endmodule

// File: rtl/hdLineCtrl.sv
module hdLineCtrl
  import hd_pkg::*;
#(
  parameter int DOTS    = 2560,
  parameter int CLK_DIV = 2,
  parameter int LOAD_W  = 4,
  parameter int OVR_W   = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pageSync,
  input  logic             lineSync,
  input  logic             quadLane,
  input  logic             exposeBusy,
  output hdCtl_t           ctl,
  output logic             headClk,
  output logic             headLoad,
  output logic             exposeStart,
  output logic [OVR_W-1:0] overrunCount
);
  localparam int SLOT_W = $clog2(DOTS);
  localparam int PH_W   = $clog2(2 * CLK_DIV);
  localparam int LD_W   = $clog2(LOAD_W + 1);

  typedef enum logic [1:0] {IDLE, SHIFT, HOLD, LOAD} state_t;
  state_t            state;
  logic              armed;
  logic              quadR;
  logic [PH_W-1:0]   phase;
  logic [SLOT_W-1:0] slot;
  logic [SLOT_W-1:0] lastSlot;
  logic [LD_W-1:0]   loadCnt;
  logic              accept;

  assign accept   = (state == IDLE) && lineSync && armed;
  assign lastSlot = quadR ? SLOT_W'(DOTS/4 - 1) : SLOT_W'(DOTS - 1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= IDLE;
      armed   <= 1'b0;
      quadR   <= 1'b0;
      phase   <= '0;
      slot    <= '0;
      loadCnt <= '0;
    end else begin
      if (pageSync) armed <= 1'b1;
      case (state)
        IDLE: if (accept) begin
          state <= SHIFT;
          quadR <= quadLane;
          phase <= '0;
          slot  <= '0;
        end
        SHIFT: if (phase == PH_W'(2*CLK_DIV - 1)) begin
          phase <= '0;
          if (slot == lastSlot) state <= HOLD;
          else slot <= slot + 1'b1;
        end else begin
          phase <= phase + 1'b1;
        end
        HOLD: if (!exposeBusy) begin
          state   <= LOAD;
          loadCnt <= '0;
        end
        LOAD: if (exposeStart) state <= IDLE;
              else loadCnt <= loadCnt + 1'b1;
        default: state <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) overrunCount <= '0;
    else if (lineSync && armed && state != IDLE && overrunCount != '1)
      overrunCount <= overrunCount + 1'b1;
  end

  assign headClk       = (state == SHIFT) && (phase >= PH_W'(CLK_DIV));
  assign headLoad      = (state == LOAD);
  assign exposeStart   = (state == LOAD) && (loadCnt == LD_W'(LOAD_W - 1));
  assign ctl.lineStart = accept;
  assign ctl.slotStart = (state == SHIFT) && (phase == '0);
  assign ctl.quad      = quadR;

  // R2
  unarmed_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !armed |-> !headClk);
  // R10
  overrun_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lineSync && armed && state != IDLE && overrunCount != '1)
      |=> overrunCount == OVR_W'($past(overrunCount) + 1'b1));
endmodule

// File: rtl/hdLineDriver.sv
module hdLineDriver
  import hd_pkg::*;
#(
  parameter int DOTS    = 2560,
  parameter int WORD_W  = 32,
  parameter int GROUPS  = 4,
  parameter int CLK_DIV = 2,
  parameter int LOAD_W  = 4,
  parameter int STRB_W  = 1024,
  parameter int OVR_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pageSync,
  input  logic              lineSync,
  input  logic              quadLane,
  input  logic [WORD_W-1:0] wordData,
  input  logic              wordValid,
  output logic              wordReady,
  output logic              headClk,
  output logic [3:0]        headData,
  output logic              headLoad,
  output logic [GROUPS-1:0] strobeN,
  output logic              underrunErr,
  output logic [OVR_W-1:0]  overrunCount
);
  hdCtl_t ctl;
  logic   exposeStart;
  logic   exposeBusy;

  hdLineCtrl #(.DOTS(DOTS), .CLK_DIV(CLK_DIV), .LOAD_W(LOAD_W), .OVR_W(OVR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .pageSync(pageSync), .lineSync(lineSync),
    .quadLane(quadLane), .exposeBusy(exposeBusy), .ctl(ctl), .headClk(headClk),
    .headLoad(headLoad), .exposeStart(exposeStart), .overrunCount(overrunCount));

  hdShiftPath #(.WORD_W(WORD_W)) u_path (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wordData(wordData), .wordValid(wordValid),
    .wordReady(wordReady), .headData(headData), .underrunErr(underrunErr));

  hdStrobeSeq #(.GROUPS(GROUPS), .STRB_W(STRB_W)) u_strb (
    .clk(clk), .rstN(rstN), .start(exposeStart), .strobeN(strobeN), .busy(exposeBusy));

  // R7
  load_strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    headLoad |-> (&strobeN));
  // R5
  fetch_clk_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    wordReady |-> !headClk);
endmodule

// File: tb/tb_hdLineDriver.sv
module tb_hdLineDriver;
  localparam int DOTS = 128, WORD_W = 32, GROUPS = 4, CLK_DIV = 2;
  localparam int LOAD_W = 3, STRB_W = 64, OVR_W = 8;
  localparam int NWORDS = DOTS / WORD_W;
  // stimulus table: {quad lane mode, word seed}
  localparam logic [32:0] VEC [4] = '{
    {1'b0, 32'hFFFF_0000}, {1'b1, 32'hA5A5_3C3C},
    {1'b0, 32'h1234_5678}, {1'b1, 32'h0F0F_F0F0}};

  logic clk = 0, rstN = 0, pageSync = 0, lineSync = 0, quadLane = 0;
  logic [WORD_W-1:0] wordData = '0;
  logic wordValid = 0, wordReady, headClk, headLoad, underrunErr;
  logic [3:0] headData;
  logic [GROUPS-1:0] strobeN;
  logic [OVR_W-1:0] overrunCount;

  hdLineDriver #(.DOTS(DOTS), .WORD_W(WORD_W), .GROUPS(GROUPS), .CLK_DIV(CLK_DIV),
    .LOAD_W(LOAD_W), .STRB_W(STRB_W), .OVR_W(OVR_W)) dut (
    .clk(clk), .rstN(rstN), .pageSync(pageSync), .lineSync(lineSync), .quadLane(quadLane),
    .wordData(wordData), .wordValid(wordValid), .wordReady(wordReady), .headClk(headClk),
    .headData(headData), .headLoad(headLoad), .strobeN(strobeN),
    .underrunErr(underrunErr), .overrunCount(overrunCount));

  always #10 clk = ~clk;  // 50 MHz

  int checks = 0, errors = 0, cycles = 0;
  logic [31:0] seed = '0;
  logic feedEn = 0, modeQ = 0;
  int idx = 0;

  function automatic logic [31:0] gen(input logic [31:0] s, input int i);
    return s ^ (32'(i) * 32'h9E37_79B9);
  endfunction

  // buffer model
  initial begin
    logic hs;
    forever begin
      @(negedge clk); hs = wordValid && wordReady;
      @(posedge clk); #1;
      if (hs) idx++;
      wordValid = feedEn;
      wordData  = gen(seed, idx);
    end
  end

  // port monitor
  logic cap [DOTS];
  int capN, laneJunk, hsCnt, loadPulses, loadCycles, ordN, overlapErr, linesDone;
  int sc [GROUPS];
  int ord [16];
  logic sawOverlap, prevClk = 0, prevLoad = 0;
  logic [GROUPS-1:0] prevAct = '0;
  always @(negedge clk) begin
    logic [GROUPS-1:0] act;
    act = ~strobeN;
    if (headClk && !prevClk) begin
      if (modeQ) begin
        for (int k = 0; k < 4; k++) if (4*capN + k < DOTS) cap[4*capN + k] = headData[k];
      end else begin
        if (capN < DOTS) cap[capN] = headData[0];
        if (headData[3:1] != 3'b000) laneJunk++;
      end
      capN++;
    end
    if (wordValid && wordReady) hsCnt++;
    if (headLoad) loadCycles++;
    if (headLoad && !prevLoad) loadPulses++;
    if ($countones(act) > 1 || (act != '0 && headLoad)) overlapErr++;
    if (headClk && act != '0) sawOverlap = 1;
    for (int g = 0; g < GROUPS; g++) if (act[g]) begin
      sc[g]++;
      if (!prevAct[g] && ordN < 16) begin ord[ordN] = g; ordN++; end
    end
    if (prevAct[GROUPS-1] && !act[GROUPS-1]) linesDone++;
    prevClk = headClk; prevLoad = headLoad; prevAct = act;
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clearStats();
    capN = 0; laneJunk = 0; hsCnt = 0; loadPulses = 0; loadCycles = 0;
    ordN = 0; overlapErr = 0; linesDone = 0; sawOverlap = 0;
    for (int g = 0; g < GROUPS; g++) sc[g] = 0;
  endtask

  task automatic pulseLine(input logic q);
    @(negedge clk); quadLane = q; lineSync = 1; idx = 0;
    @(negedge clk); lineSync = 0;
  endtask

  function automatic int dataErrs(input logic zeros);
    int n = 0;
    for (int i = 0; i < DOTS; i++) begin
      logic e;
      logic [31:0] w;
      w = gen(seed, i / 32);
      e = zeros ? 1'b0 : w[i % 32];
      if (cap[i] !== e) n++;
    end
    return n;
  endfunction

  task automatic waitLines(input int n);
    while (linesDone < n) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk); cycles++;
      if (cycles > 150000) begin
        errors++; checks++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    clearStats();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(strobeN == '1 && !headLoad && !headClk && !wordReady, "R1 idle outputs", int'(strobeN), 15);
    chk(!underrunErr && overrunCount == 0, "R1 error state", int'(overrunCount), 0);
    rstN = 1; feedEn = 1;
    repeat (2) @(negedge clk);
    // R2 line before page sync
    pulseLine(0);
    repeat (200) @(negedge clk);
    chk(capN == 0, "R2 no head clock unarmed", capN, 0);
    chk(overrunCount == 0, "R2 no overrun unarmed", int'(overrunCount), 0);
    @(negedge clk); pageSync = 1; @(negedge clk); pageSync = 0;

    // table of patterns (R3 R4 R5 R6 R7)
    for (int v = 0; v < 4; v++) begin
      clearStats();
      seed = VEC[v][31:0]; modeQ = VEC[v][32];
      pulseLine(modeQ);
      waitLines(1);
      chk(capN == (modeQ ? DOTS/4 : DOTS), modeQ ? "R4 clock count" : "R3 clock count",
          capN, modeQ ? DOTS/4 : DOTS);
      chk(dataErrs(0) == 0 && laneJunk == 0, modeQ ? "R4 lane data" : "R3 serial data",
          dataErrs(0) + laneJunk, 0);
      chk(hsCnt == NWORDS, "R5 words per line", hsCnt, NWORDS);
      chk(loadPulses == 1 && loadCycles == LOAD_W, "R6 load pulse", loadCycles, LOAD_W);
      chk(ordN == GROUPS && ord[0] == 0 && ord[1] == 1 && ord[2] == 2 && ord[3] == 3,
          "R7 strobe order", ordN, GROUPS);
      for (int g = 0; g < GROUPS; g++) chk(sc[g] == STRB_W, "R7 strobe width", sc[g], STRB_W);
      chk(overlapErr == 0, "R7 exclusive strobes", overlapErr, 0);
    end

    // R8 R6: next line shifts during exposure, latch waits
    clearStats();
    seed = 32'hC0DE_0001; modeQ = 1;
    pulseLine(1);
    while (strobeN == '1) @(negedge clk);
    capN = 0; seed = 32'h5EED_7777;
    pulseLine(1);
    waitLines(2);
    chk(sawOverlap == 1, "R8 shift overlaps strobes", int'(sawOverlap), 1);
    chk(dataErrs(0) == 0, "R8 second line data", dataErrs(0), 0);
    chk(loadPulses == 2 && overlapErr == 0, "R6 load waits for exposure", overlapErr, 0);
    chk(sc[0] == 2*STRB_W && sc[3] == 2*STRB_W, "R7 two exposures", sc[3], 2*STRB_W);

    // R10 overrun during shift
    clearStats();
    seed = 32'h0BAD_F00D; modeQ = 0;
    pulseLine(0);
    repeat (20) @(negedge clk);
    @(negedge clk); lineSync = 1; @(negedge clk); lineSync = 0;
    chk(overrunCount == 1, "R10 overrun counted", int'(overrunCount), 1);
    waitLines(1);
    repeat (300) @(negedge clk);
    chk(capN == DOTS && dataErrs(0) == 0, "R10 line unaffected", capN, DOTS);
    chk(loadPulses == 1, "R10 no extra line", loadPulses, 1);

    // R9 underrun
    clearStats();
    feedEn = 0; modeQ = 0; seed = 32'hFFFF_FFFF;
    chk(underrunErr == 0, "R9 flag clear before", int'(underrunErr), 0);
    pulseLine(0);
    waitLines(1);
    chk(underrunErr == 1, "R9 flag set", int'(underrunErr), 1);
    chk(dataErrs(1) == 0, "R9 blank dots", dataErrs(1), 0);
    clearStats(); feedEn = 1; modeQ = 1;
    pulseLine(1);
    waitLines(1);
    chk(dataErrs(0) == 0, "R9 recovery data", dataErrs(0), 0);
    chk(underrunErr == 1, "R9 flag sticky", int'(underrunErr), 1);
    @(negedge clk); rstN = 0; @(negedge clk);
    chk(underrunErr == 0 && overrunCount == 0, "R1 R9 cleared by reset", int'(underrunErr), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule